// File: doc/BRIEF.md
# System Data Bus Fill Turnaround Controller

This block sits on the processor side of a 64-bit bidirectional system data bus and runs in the core clock domain. It takes decoded data-control commands, which are either fills (inbound data) or writes (outbound data), and drives the bus output enable. It also times the capture of inbound fill data. When a fill command arrives, the block switches the output drivers off after a fixed turnaround delay. If an outbound write is still in progress at that point, the block cuts it off and flags it so the write source can replay it. The drivers then stay off for the whole fill.

Each fill carries a fixed number of beats. The first beat is captured at a base latency plus a 5-bit programmable delay. Later beats follow at a programmable interval. The delay and the interval are both taken at the moment the fill command arrives. A write command that arrives while a fill is pending overrides the fill. The block does no arbitration: scheduling fills and writes so they do not collide on the bus is left to the external system.

Top module: `fill_turnaround_ctrl`

## Requirements
- R1: After reset, `drv_oe`, `wr_abort`, `cap_stb` and `fill_done` are all low, and no fill is pending.
- R2: A command is taken only when `cmd_valid` is high. Codes 1 to 5 are fills, codes 6 and 7 are writes, and code 0 is ignored. A code presented while `cmd_valid` is low has no effect.
- R3: The fill command is sampled at clock edge E0. For every fill code, `drv_oe` reads low after edge E0+3, provided no other command arrives in between.
- R4: In the cycle that `drv_oe` falls because of a fill, `wr_abort` pulses high for one cycle if `drv_oe` was high and `wr_busy` was high. Otherwise `wr_abort` stays low.
- R5: `drv_oe` rises only on the edge that samples a write command. It stays low throughout a fill that no write interrupts.
- R6: The first capture strobe `cap_stb` is high after edge E0+10+D, where D is `delay_cfg` (0 to 31). It comes with `cap_beat` = 0.
- R7: The remaining 7 strobes of a fill follow at intervals of `gap_cfg`+1 cycles, with `cap_beat` counting 1 to 7. Each strobe lasts one cycle.
- R8: `fill_done` pulses for one cycle, in the cycle right after the strobe of beat 7.
- R9: `delay_cfg` and `gap_cfg` are sampled only at the fill command. Changing them during a fill does not alter that fill's timing.
- R10: A write command during a pending fill cancels that fill. There are no further strobes and no `fill_done`. `drv_oe` is high from the next cycle, and a turnoff that has not yet happened is cancelled, so there is no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Data-control command present |
| cmd_code | input | 3 | Command code: 0 none, 1-5 fill, 6-7 write |
| delay_cfg | input | 5 | Extra capture delay D in core cycles |
| gap_cfg | input | 3 | Beat interval minus one |
| wr_busy | input | 1 | Outbound write transfer in progress |
| drv_oe | output | 1 | Data bus output enable |
| wr_abort | output | 1 | One-cycle pulse: outbound write cut off |
| cap_stb | output | 1 | Capture strobe for one fill beat |
| cap_beat | output | 3 | Index of the beat being captured |
| fill_done | output | 1 | One-cycle pulse after the last beat |

## Verification
The bench sweeps every delay value against several beat intervals, rotating through all five fill codes. In each run it checks the exact cycle of the first strobe and of every later strobe. An off-by-one in the base latency or the interval reload would show up as a shifted strobe or a wrong beat index. The configuration inputs are scrambled right after each fill command, so a design that reads them live would drift. Writes are injected before and after the driver turnoff. A design that let the turnoff still happen, or kept strobing after the override, would show a low enable or stray strobes. The bench also checks that only a write reopens the drivers and that ignored commands leave the bus state alone.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_FILL  = 2'd1,
    KIND_WRITE = 2'd2
  } cmd_kind_e;

  // Code 0 is a no-op, 1..5 are the fill flavours, 6..7 are writes.
  function automatic cmd_kind_e classify(input logic vld, input logic [CODE_W-1:0] code);
    cmd_kind_e k;
    k = KIND_NONE;
    if (vld) begin
      if (code >= 3'd1 && code <= 3'd5) k = KIND_FILL;
      else if (code >= 3'd6)            k = KIND_WRITE;
    end
    return k;
  endfunction
endpackage

// File: rtl/ftc_cmd_decode.sv
module ftc_cmd_decode
  import ftc_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              fill_cmd,
  output logic              wr_cmd
);
  cmd_kind_e kind;

  always_comb begin
    kind     = classify(cmd_valid, cmd_code);
    fill_cmd = (kind == KIND_FILL);
    wr_cmd   = (kind == KIND_WRITE);
  end
endmodule

// File: rtl/ftc_oe_seq.sv
module ftc_oe_seq #(
  parameter int TURN_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fill_cmd,
  input  logic wr_cmd,
  input  logic wr_busy,
  output logic drv_oe,
  output logic wr_abort
);
  localparam int CNT_W = $clog2(TURN_LAT + 1);

  logic             arm_q, arm_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             oe_q, oe_d;
  logic             abort_q, abort_d;
  logic             cnt_en;

  always_comb begin
    arm_d   = arm_q;
    cnt_d   = cnt_q;
    oe_d    = oe_q;
    abort_d = 1'b0;
    cnt_en  = 1'b0;
    if (wr_cmd) begin
      oe_d  = 1'b1;
      arm_d = 1'b0;
    end else if (fill_cmd) begin
      arm_d  = 1'b1;
      cnt_en = 1'b1;
      cnt_d  = CNT_W'(TURN_LAT - 1);
    end else if (arm_q) begin
      if (cnt_q == '0) begin
        arm_d   = 1'b0;
        oe_d    = 1'b0;
        abort_d = oe_q & wr_busy;
      end else begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      arm_q   <= arm_d;
      oe_q    <= oe_d;
      abort_q <= abort_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign drv_oe   = oe_q;
  assign wr_abort = abort_q;
endmodule

// File: rtl/ftc_cap_timer.sv
module ftc_cap_timer #(
  parameter int BASE_LAT = 10,
  parameter int DLY_W    = 5,
  parameter int GAP_W    = 3,
  parameter int BEATS    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fill_cmd,
  input  logic                     wr_cmd,
  input  logic [DLY_W-1:0]         delay_cfg,
  input  logic [GAP_W-1:0]         gap_cfg,
  output logic                     cap_stb,
  output logic [$clog2(BEATS)-1:0] cap_beat,
  output logic                     fill_done
);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int MAXW   = BASE_LAT + (1 << DLY_W) + (1 << GAP_W);
  localparam int WAIT_W = $clog2(MAXW);

  logic              active_q, active_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              stb_q, stb_d;
  logic [BEAT_W-1:0] sbeat_q, sbeat_d;
  logic              last_q, last_d;
  logic              done_q, done_d;

  always_comb begin
    active_d = active_q;
    wait_d   = wait_q;
    gap_d    = gap_q;
    beat_d   = beat_q;
    sbeat_d  = sbeat_q;
    stb_d    = 1'b0;
    last_d   = 1'b0;
    done_d   = last_q;
    if (wr_cmd) begin
      active_d = 1'b0;
    end else if (fill_cmd) begin
      active_d = 1'b1;
      wait_d   = WAIT_W'(BASE_LAT - 1) + WAIT_W'(delay_cfg);
      gap_d    = gap_cfg;
      beat_d   = '0;
    end else if (active_q) begin
      if (wait_q == '0) begin
        stb_d   = 1'b1;
        sbeat_d = beat_q;
        wait_d  = WAIT_W'(gap_q);
        if (beat_q == BEAT_W'(BEATS - 1)) begin
          active_d = 1'b0;
          last_d   = 1'b1;
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end else begin
        wait_d = wait_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wait_q   <= '0;
      gap_q    <= '0;
      beat_q   <= '0;
      stb_q    <= 1'b0;
      sbeat_q  <= '0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      wait_q   <= wait_d;
      gap_q    <= gap_d;
      beat_q   <= beat_d;
      stb_q    <= stb_d;
      sbeat_q  <= sbeat_d;
      last_q   <= last_d;
      done_q   <= done_d;
    end
  end

  assign cap_stb   = stb_q;
  assign cap_beat  = sbeat_q;
  assign fill_done = done_q;
endmodule

// File: rtl/fill_turnaround_ctrl.sv
module fill_turnaround_ctrl #(
  parameter int TURN_LAT = 3,
  parameter int BASE_LAT = 10,
  parameter int DLY_W    = 5,
  parameter int GAP_W    = 3,
  parameter int BEATS    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_code,
  input  logic [DLY_W-1:0]         delay_cfg,
  input  logic [GAP_W-1:0]         gap_cfg,
  input  logic                     wr_busy,
  output logic                     drv_oe,
  output logic                     wr_abort,
  output logic                     cap_stb,
  output logic [$clog2(BEATS)-1:0] cap_beat,
  output logic                     fill_done
);
  logic fill_cmd;
  logic wr_cmd;

  ftc_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .fill_cmd  (fill_cmd),
    .wr_cmd    (wr_cmd)
  );

  ftc_oe_seq #(.TURN_LAT(TURN_LAT)) u_oe (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_cmd (fill_cmd),
    .wr_cmd   (wr_cmd),
    .wr_busy  (wr_busy),
    .drv_oe   (drv_oe),
    .wr_abort (wr_abort)
  );

  ftc_cap_timer #(
    .BASE_LAT (BASE_LAT),
    .DLY_W    (DLY_W),
    .GAP_W    (GAP_W),
    .BEATS    (BEATS)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_cmd  (fill_cmd),
    .wr_cmd    (wr_cmd),
    .delay_cfg (delay_cfg),
    .gap_cfg   (gap_cfg),
    .cap_stb   (cap_stb),
    .cap_beat  (cap_beat),
    .fill_done (fill_done)
  );
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
  parameter int BEATS = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_valid,
  input logic                     fill_cmd,
  input logic                     wr_cmd,
  input logic                     wr_busy,
  input logic                     drv_oe,
  input logic                     wr_abort,
  input logic                     cap_stb,
  input logic [$clog2(BEATS)-1:0] cap_beat,
  input logic                     fill_done
);
  logic [2:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 1'b1;
  end

  // R3: a fill followed by three quiet cycles leaves the drivers off
  assert_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd5) && $past(fill_cmd, 4) && !$past(cmd_valid, 3) &&
    !$past(cmd_valid, 2) && !$past(cmd_valid, 1) |-> !drv_oe);

  // R4: abort only together with a driver drop during an active write
  assert_abort_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd2) && wr_abort |-> !drv_oe && $past(drv_oe) && $past(wr_busy));

  // R5: drivers reopen only because of a write command
  assert_oe_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd2) && $rose(drv_oe) |-> $past(wr_cmd));

  // R8: completion follows the strobe of the final beat
  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd2) && fill_done |-> $past(cap_stb) && ($past(cap_beat) == BEATS - 1));

  // R10: a write stops capture and enables drivers next cycle
  assert_write_override_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> drv_oe && !cap_stb);
endmodule

bind fill_turnaround_ctrl ftc_checker #(.BEATS(BEATS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .fill_cmd  (fill_cmd),
  .wr_cmd    (wr_cmd),
  .wr_busy   (wr_busy),
  .drv_oe    (drv_oe),
  .wr_abort  (wr_abort),
  .cap_stb   (cap_stb),
  .cap_beat  (cap_beat),
  .fill_done (fill_done)
);

// File: tb/fill_turnaround_ctrl_tb_top.sv
module fill_turnaround_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_code;
  logic [4:0] delay_cfg;
  logic [2:0] gap_cfg;
  logic       wr_busy;
  logic       drv_oe;
  logic       wr_abort;
  logic       cap_stb;
  logic [2:0] cap_beat;
  logic       fill_done;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit finished = 0;

  fill_turnaround_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .delay_cfg (delay_cfg),
    .gap_cfg   (gap_cfg),
    .wr_busy   (wr_busy),
    .drv_oe    (drv_oe),
    .wr_abort  (wr_abort),
    .cap_stb   (cap_stb),
    .cap_beat  (cap_beat),
    .fill_done (fill_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      report();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [2:0] code);
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 3'd0;
  endtask

  // Issue a fill; optionally a write at relative cycle ov (-1 = none)
  task automatic run_fill(input logic [2:0] code, input int d, input int g,
                          input bit busy, input int ov);
    int first, last, k_end;
    bit cut;
    bit e_stb;
    send(3'd6);
    chk("R5 write opens drivers", drv_oe, 1);
    wr_busy   = busy;
    delay_cfg = d[4:0];
    gap_cfg   = g[2:0];
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 3'd0;
    delay_cfg = ~d[4:0];   // R9: must not matter
    gap_cfg   = ~g[2:0];
    first = 10 + d;
    last  = first + 7 * (g + 1);
    k_end = last + 3;
    for (int k = 0; k <= k_end; k++) begin
      cut   = (ov >= 0) && (k > ov);
      e_stb = !cut && k >= first && k <= last && ((k - first) % (g + 1) == 0);
      chk("R3/R5/R10 drv_oe", drv_oe, cut ? 1 : (k < 3 ? 1 : 0));
      chk("R4 wr_abort", wr_abort, (!cut && k == 3 && busy) ? 1 : 0);
      chk("R6/R7/R9/R10 cap_stb", cap_stb, e_stb);
      if (e_stb) chk("R7 cap_beat", cap_beat, (k - first) / (g + 1));
      chk("R8 fill_done", fill_done, (!cut && k == last + 1) ? 1 : 0);
      if (k == ov) begin
        cmd_valid = 1'b1;
        cmd_code  = 3'd7;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_code  = 3'd0;
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_code  = 3'd0;
    delay_cfg = 5'd0;
    gap_cfg   = 3'd0;
    wr_busy   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 drv_oe", drv_oe, 0);
    chk("R1 wr_abort", wr_abort, 0);
    chk("R1 cap_stb", cap_stb, 0);
    chk("R1 fill_done", fill_done, 0);

    // Sweep delay x gap, cycling through all fill codes (R2/R3/R6/R7)
    for (int d = 0; d < 32; d++) begin
      for (int g = 0; g < 4; g++) begin
        run_fill(3'(1 + ((d * 4 + g) % 5)), d, g, ((d + g) % 2) == 0, -1);
      end
    end
    run_fill(3'd5, 31, 7, 1'b1, -1);

    // R10 overrides before and after the turnoff point
    run_fill(3'd1, 20, 1, 1'b1, 1);
    run_fill(3'd3, 20, 1, 1'b1, 15);
    run_fill(3'd4, 0, 2, 1'b1, 14);

    // R2: no-op code and invalid strobes are ignored
    send(3'd6);
    wr_busy = 1'b1;
    send(3'd0);
    cmd_code = 3'd2;          // fill code with valid low
    for (int k = 0; k < 45; k++) begin
      chk("R2 ignored drv_oe", drv_oe, 1);
      chk("R2 ignored cap_stb", cap_stb, 0);
      chk("R2 ignored wr_abort", wr_abort, 0);
      @(negedge clk);
    end
    cmd_code = 3'd0;
    report();
  end
endmodule